// File: doc/BRIEF.md
# PWM Period Dithering Generator

This block produces single-slope pulse-width-modulated waveforms whose average period and duty can land between whole counter steps. A free-running counter climbs from zero to a per-frame top value and then wraps. Each wrap starts a new frame. Every channel output is high from the start of the frame until the counter reaches that channel's compare value for the frame, and low for the rest of the frame.

In the three dithering modes, the low bits of the period value and of each compare value are not used as timing directly. Instead they are a count of how many frames, within a repeating cycle of 16, 32 or 64 frames, get one extra counter clock. The remaining upper bits set the base period or base duty. Period dithering and duty dithering run independently, each from its own value's low bits. The stretched frames are spread evenly across the cycle by an accumulator-overflow rule.

New period, compare and mode values are sampled only at a frame boundary. A one-cycle pulse marks the first clock of every frame.

Top module: `pwmd_gen`

## Requirements
- R1: While reset is asserted, and from the first clock edge at which `en` is sampled low, every `pwm_out` bit and `frame_start` are 0.
- R2: With `dith_mode` = 0, every frame lasts `period`+1 clocks. Channel c is high for the first min(`compare`[c], `period`+1) clocks of the frame.
- R3: `frame_start` is high in exactly the first clock of each frame. The first frame begins in the clock after the edge at which `en` is first sampled high.
- R4: `dith_mode` code 1, 2 or 3 selects D = 4, 5 or 6 dither bits and a cycle of L = 2^D frames. The dither count is bits [D-1:0] of the value, and the base value is the value shifted right by D.
- R5: In a dithering mode, frame k of the cycle lasts (`period`>>D)+1+e clocks, where e = floor((k+1)·N/L) − floor(k·N/L) and N = `period`[D-1:0].
- R6: Over any whole cycle of L frames, exactly N frames are one clock longer than the base period.
- R7: In a dithering mode, channel c is high for min((`compare`[c]>>D)+e_c, frame length) clocks of frame k, where e_c uses the same rule with that channel's own dither count. Duty dithering is independent of period dithering.
- R8: A compare value of 0 keeps a channel low for the whole frame. A compare value at or above the frame length keeps it high for the whole frame.
- R9: Changes to `period`, `compare` or `dith_mode` during a frame leave that frame untouched and take effect from the next frame.
- R10: After `en` drops and rises again, frame numbering restarts at k = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low stops and clears the counter |
| dith_mode | input | 2 | 0 plain, 1/2/3 dithering over 16/32/64 frames |
| period | input | CNT_W | Period value (top count plus dither count) |
| compare | input | NUM_CH*CNT_W | Compare values, channel c in bits [c*CNT_W +: CNT_W] |
| pwm_out | output | NUM_CH | PWM waveforms, one per channel |
| frame_start | output | 1 | One-clock pulse in the first clock of each frame |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that `CNT_W` is wide enough that the base period plus one extra clock never wraps the counter. The bench keeps within both: it holds reset for several cycles and draws base periods far below the counter range. Apart from one directed case that alters the period and compare values in the middle of a frame, the bench changes inputs only while `en` is low. With inputs held steady, each measured frame can therefore be matched against a frame index that the bench counts from enable.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;

  localparam int IDX_W = 6;

  // number of dither bits selected by the mode code
  function automatic int unsigned dith_bits(input logic [1:0] mode);
    case (mode)
      2'd1:    return 4;
      2'd2:    return 5;
      2'd3:    return 6;
      default: return 0;
    endcase
  endfunction

  // accumulator-overflow spread: frame k gets an extra clock when
  // ((k*n) mod L) + n reaches L
  function automatic logic dith_hit(input logic [IDX_W-1:0] idx,
                                    input logic [31:0] raw,
                                    input logic [1:0] mode);
    int unsigned db, len, k, n, acc;
    db = dith_bits(mode);
    if (db == 0) return 1'b0;
    len = 32'd1 << db;
    k   = 32'(idx) & (len - 1);
    n   = raw & (len - 1);
    acc = ((k * n) & (len - 1)) + n;
    return acc >= len;
  endfunction

  // effective value for one frame: base (upper bits) plus dither extra
  function automatic logic [31:0] dith_value(input logic [31:0] raw,
                                             input logic [1:0] mode,
                                             input logic [IDX_W-1:0] idx);
    logic [31:0] base;
    base = raw >> dith_bits(mode);
    return base + {31'd0, dith_hit(idx, raw, mode)};
  endfunction

endpackage

// File: rtl/pwmd_frame_ctl.sv
module pwmd_frame_ctl
  import pwmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [1:0]           dith_mode,
  input  logic [CNT_W-1:0]     period,
  output logic                 running,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     top_q,
  output logic [IDX_W-1:0]     frame_idx,
  output logic                 load,
  output logic [IDX_W-1:0]     next_idx
);

  logic             last_clk;
  logic [31:0]      top_wide;
  logic [CNT_W-1:0] top_next;

  assign last_clk = (cnt == top_q);
  assign load     = en && (!running || last_clk);
  assign next_idx = running ? frame_idx + 1'b1 : '0;
  assign top_wide = dith_value(32'(period), dith_mode, next_idx);
  assign top_next = top_wide[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cnt       <= '0;
      top_q     <= '0;
      frame_idx <= '0;
    end else if (!en) begin
      running   <= 1'b0;
      cnt       <= '0;
      frame_idx <= '0;
    end else if (load) begin
      running   <= 1'b1;
      cnt       <= '0;
      top_q     <= top_next;
      frame_idx <= next_idx;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwmd_channel.sv
module pwmd_channel
  import pwmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [IDX_W-1:0]   next_idx,
  input  logic [1:0]         dith_mode,
  input  logic [CNT_W-1:0]   compare,
  input  logic               running,
  input  logic [CNT_W-1:0]   cnt,
  output logic               pwm
);

  logic [CNT_W-1:0] cmp_q;
  logic [31:0]      cmp_wide;

  assign cmp_wide = dith_value(32'(compare), dith_mode, next_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cmp_q <= '0;
    else if (load) cmp_q <= cmp_wide[CNT_W-1:0];
  end

  assign pwm = running && (cnt < cmp_q);

endmodule

// File: rtl/pwmd_gen.sv
module pwmd_gen
  import pwmd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [1:0]                dith_mode,
  input  logic [CNT_W-1:0]          period,
  input  logic [NUM_CH*CNT_W-1:0]   compare,
  output logic [NUM_CH-1:0]         pwm_out,
  output logic                      frame_start
);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_q;
  logic [IDX_W-1:0] frame_idx;
  logic             load;
  logic [IDX_W-1:0] next_idx;

  pwmd_frame_ctl #(.CNT_W(CNT_W)) frame_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .dith_mode (dith_mode),
    .period    (period),
    .running   (running),
    .cnt       (cnt),
    .top_q     (top_q),
    .frame_idx (frame_idx),
    .load      (load),
    .next_idx  (next_idx)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwmd_channel #(.CNT_W(CNT_W)) ch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .next_idx  (next_idx),
      .dith_mode (dith_mode),
      .compare   (compare[c*CNT_W +: CNT_W]),
      .running   (running),
      .cnt       (cnt),
      .pwm       (pwm_out[c])
    );
  end

  assign frame_start = running && (cnt == '0);

endmodule

// File: rtl/pwmd_chk.sv
module pwmd_chk
  import pwmd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               running,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   top_q,
  input logic [IDX_W-1:0]   frame_idx,
  input logic               frame_start,
  input logic [NUM_CH-1:0]  pwm_out
);

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_out == '0) && !frame_start);

  // R3
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && (top_q != '0) |=> !frame_start);

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt <= top_q);

  // R9
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !frame_start |-> $stable(top_q));

  // R10
  index_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (frame_idx == '0) && frame_start);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
    // R7
    no_mid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && !frame_start && pwm_out[c] |-> $past(pwm_out[c]));
  end

endmodule

bind pwmd_gen pwmd_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .running     (running),
  .cnt         (cnt),
  .top_q       (top_q),
  .frame_idx   (frame_idx),
  .frame_start (frame_start),
  .pwm_out     (pwm_out)
);

// File: tb/pwmd_gen_tb.sv
module pwmd_gen_tb_top;

  localparam int W  = 16;
  localparam int NC = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b0;
  logic [1:0]      dith_mode = 2'd0;
  logic [W-1:0]    period = '0;
  logic [NC*W-1:0] compare = '0;
  logic [NC-1:0]   pwm_out;
  logic            frame_start;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwmd_gen #(.CNT_W(W), .NUM_CH(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .dith_mode(dith_mode),
    .period(period), .compare(compare),
    .pwm_out(pwm_out), .frame_start(frame_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dbits(input int mode);
    return (mode == 0) ? 0 : mode + 3;
  endfunction

  // extra clock for frame k with count n over cycle length l
  function automatic int extra(input int k, input int n, input int l);
    return ((k + 1) * n) / l - (k * n) / l;
  endfunction

  function automatic int eff(input int raw, input int mode, input int k);
    int d, l;
    d = dbits(mode);
    if (d == 0) return raw;
    l = 1 << d;
    return (raw >> d) + extra(k % l, raw % l, l);
  endfunction

  // measure nfr frames from enable with steady inputs
  task automatic run_case(input int mode, input int per, input int c0, input int c1,
                          input int nfr);
    int l, ext_sum, exp_len, len, hi0, hi1, e0, e1;
    en = 1'b0;
    @(negedge clk);
    chk(pwm_out == '0 && !frame_start, "R1", int'(pwm_out), 0);
    dith_mode = 2'(mode);
    period    = W'(per);
    compare   = {W'(c1), W'(c0)};
    en = 1'b1;
    @(negedge clk);
    chk(frame_start == 1'b1, "R3", int'(frame_start), 1);
    l = 1 << dbits(mode);
    ext_sum = 0;
    for (int k = 0; k < nfr; k++) begin
      len = 0; hi0 = 0; hi1 = 0;
      do begin
        len++;
        hi0 += int'(pwm_out[0]);
        hi1 += int'(pwm_out[1]);
        @(negedge clk);
        if (len > 1 && len < 4 && frame_start && len != 1) begin end
      end while (!frame_start && len < 100000);
      exp_len = eff(per, mode, k) + 1;
      if (mode == 0) chk(len == exp_len, "R2", len, exp_len);
      else           chk(len == exp_len, "R5", len, exp_len);
      e0 = eff(c0, mode, k); if (e0 > exp_len) e0 = exp_len;
      e1 = eff(c1, mode, k); if (e1 > exp_len) e1 = exp_len;
      chk(hi0 == e0, (mode == 0) ? "R2" : "R7", hi0, e0);
      chk(hi1 == e1, (mode == 0) ? "R8" : "R7", hi1, e1);
      if (mode != 0) begin
        ext_sum += len - ((per >> dbits(mode)) + 1);
        if ((k % l) == l - 1) begin
          // R6 / R4: whole cycle of L = 2^D frames
          chk(ext_sum == per % l, "R6", ext_sum, per % l);
          ext_sum = 0;
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    int len;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pwm_out == '0 && frame_start == 1'b0, "R1", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_out == '0 && frame_start == 1'b0, "R1", int'(frame_start), 0);

    // R2 plain mode, R8 zero and oversize compare
    run_case(0, 9, 4, 0, 3);
    run_case(0, 5, 0, 40, 3);
    run_case(0, 0, 1, 0, 3);
    // R4 each dither mode, directed counts
    run_case(1, (7 << 4) | 5, (3 << 4) | 11, (9 << 4), 32);
    run_case(2, (3 << 5) | 31, (1 << 5) | 1, (2 << 5) | 17, 32);
    run_case(3, (2 << 6) | 1, 0, (20 << 6) | 63, 64);
    run_case(3, (4 << 6), (2 << 6) | 32, 5, 64);
    // constrained random, R5 R6 R7 R10
    for (int t = 0; t < 8; t++) begin
      int m, d, per, c0, c1;
      m   = 1 + int'($urandom_range(0, 2));
      d   = dbits(m);
      per = (int'($urandom_range(1, 12)) << d) | int'($urandom_range(0, (1 << d) - 1));
      c0  = int'($urandom_range(0, per));
      c1  = int'($urandom_range(0, per + (4 << d)));
      run_case(m, per, c0, c1, 1 << d);
    end
    run_case(0, int'($urandom_range(3, 30)), int'($urandom_range(0, 40)),
             int'($urandom_range(0, 40)), 4);

    // R9: change values mid-frame in plain mode
    en = 1'b0;
    @(negedge clk);
    dith_mode = 2'd0; period = W'(20); compare = {W'(30), W'(6)};
    en = 1'b1;
    @(negedge clk);
    chk(frame_start == 1'b1, "R3", int'(frame_start), 1);
    len = 1;
    repeat (4) begin @(negedge clk); len++; end
    period = W'(9); compare = {W'(0), W'(2)};
    do begin
      @(negedge clk);
      len++;
    end while (!frame_start && len < 1000);
    chk(len == 22, "R9", len - 1, 21);
    len = 0;
    do begin
      len++;
      @(negedge clk);
    end while (!frame_start && len < 1000);
    chk(len == 10, "R9", len, 10);

    // R1/R10: drop enable
    en = 1'b0;
    @(negedge clk);
    chk(pwm_out == '0 && !frame_start, "R10", int'(pwm_out), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule